// File: doc/BRIEF.md
# 32x32 Hardware Cursor Overlay

This block sits in a display scan-out path, after palette lookup. Each cycle it may receive one pixel that already holds its final colour, along with the pixel's column and line coordinates. The block decides whether a 32x32 two-colour cursor covers that pixel. Where the cursor is opaque, it replaces the pixel with one of two overlay colours. It emits the result one clock later, together with a valid flag and the coordinates, both delayed by the same amount.

The cursor shape is held in two planes of 32 words each. The first is a transparency plane that says which cursor pixels are opaque. The second is a colour-select plane that picks between the two overlay colours. Both planes, together with a packed column/line position word and a general-purpose control word, are reached through a simple 32-bit register bus. The two overlay colours are supplied, already resolved, by the palette logic outside this block.

Top module: `cursor_overlay`

## Requirements
- R1: After reset the cursor position holds column 0xF000 and line 0xF000, so no pixel is overlaid, and `out_valid` is 0.
- R2: `out_valid`, `out_x` and `out_y` are copies of `in_valid`, `in_x` and `in_y` delayed by exactly one clock. `out_pixel` belongs to the same delayed pixel.
- R3: A write to byte offset 0x8FC sets the position. Data bits [31:16] give the cursor column X and bits [15:0] give the cursor line Y.
- R4: A write to offset 0x900+4r (r = 0..31) stores transparency row r. A write to offset 0x980+4r stores colour-select row r.
- R5: A pixel on line L can be overlaid only when Y <= L < Y+32. It then uses row L-Y.
- R6: A pixel at column P can be overlaid only when X <= P < X+32. Cursor column k = P-X uses bit 31-k of both row words, so the leftmost cursor column is bit 31.
- R7: For a covered pixel whose transparency bit is 1, the output is `ovl_colour1` if its colour-select bit is 1 and `ovl_colour0` if that bit is 0. Where the transparency bit is 0, the input pixel passes through unchanged.
- R8: Nothing is overlaid at a column P >= ACTIVE_W (default 1024). The cursor is therefore clipped at the right edge, and a cursor with X >= ACTIVE_W is not drawn.
- R9: A read takes effect at the next clock edge and is held on `reg_rdata`. A read of offset 0x818 returns the last value written there with bit 25 set to 1. A read of any other offset returns zero.
- R10: A register write affects pixels presented from the next clock onwards. A write whose offset is not word aligned, or that falls outside the mapped offsets, changes no cursor state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| ovl_colour0 | input | PIX_W | Overlay colour when the colour-select bit is 0 |
| ovl_colour1 | input | PIX_W | Overlay colour when the colour-select bit is 1 |
| in_valid | input | 1 | Input pixel valid |
| in_x | input | 16 | Input pixel column |
| in_y | input | 16 | Input pixel line |
| in_pixel | input | PIX_W | Input pixel colour |
| out_valid | output | 1 | Output pixel valid |
| out_x | output | 16 | Output pixel column |
| out_y | output | 16 | Output pixel line |
| out_pixel | output | PIX_W | Output pixel colour |

## Verification
The bench probes each edge of the cursor box: the first and last line, the first and 32nd column, one pixel outside each of them, and a cursor that crosses the right edge of the active area.

Each probe targets a specific fault:
- Reversed bit order inside a row would paint the mirror image of the cursor.
- Off-by-one window limits would paint a 33rd column or line, or drop the last one.
- A missing clip would draw beyond the active width.

Further probes cover the register side:
- A wrong reset position would show the cursor at the top-left corner straight after reset.
- Loose address decoding would let misaligned or neighbouring writes corrupt the shape or the position.
- Reads that leak other registers, or that fail to force bit 25, show up as wrong read data.

Random positions and shapes, compared against a bench model, then cover the colour selection in general.

// File: rtl/curs_ovl_pkg.sv
// Package: shared constants and types for the cursor overlay.
// Assumes: 32-bit register bus, byte offsets, word-aligned accesses.
package curs_ovl_pkg;
    localparam int unsigned REG_AW     = 12;
    localparam int unsigned REG_DW     = 32;
    localparam int unsigned COORD_W    = 16;
    localparam int unsigned CUR_DIM    = 32;
    localparam int unsigned CUR_IDX_W  = $clog2(CUR_DIM);
    localparam int unsigned MISC_FORCE = 25;

    localparam logic [REG_AW-1:0] OFS_POS  = 12'h8FC;
    localparam logic [REG_AW-1:0] OFS_MISC = 12'h818;
    // Upper offset bits selecting each shape plane (one word per row).
    localparam logic [4:0] OPAQ_PAGE = 5'b10010;
    localparam logic [4:0] SEL_PAGE  = 5'b10011;

    localparam logic [COORD_W-1:0] PARK_COORD = 16'hF000;

    typedef struct packed {
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
    } cur_pos_t;
endpackage

// File: rtl/cur_regs.sv
// Module: cur_regs
// Holds the cursor position, the two 32-row shape planes and the control
// word. Writes land at the clock edge. Reads are registered and held.
// Assumes: only word-aligned offsets are decoded; others are dropped.
module cur_regs
    import curs_ovl_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [REG_AW-1:0]     addr,
    input  logic [REG_DW-1:0]     wdata,
    output logic [REG_DW-1:0]     rdata,
    input  logic [CUR_IDX_W-1:0]  row_idx,
    output logic [CUR_DIM-1:0]    opaq_row,
    output logic [CUR_DIM-1:0]    sel_row,
    output cur_pos_t              pos
);
    logic [CUR_DIM-1:0] opaq_q [CUR_DIM];
    logic [CUR_DIM-1:0] sel_q  [CUR_DIM];
    cur_pos_t           pos_q;
    logic [REG_DW-1:0]  misc_q;

    logic                 aligned;
    logic                 opaq_wr;
    logic                 sel_wr;
    logic [CUR_IDX_W-1:0] wr_row;

    // Decode of a write into one of the register groups.
    always_comb begin
        aligned = (addr[1:0] == 2'b00);
        opaq_wr = wr_en && aligned && (addr[11:7] == OPAQ_PAGE);
        sel_wr  = wr_en && aligned && (addr[11:7] == SEL_PAGE);
        wr_row  = addr[CUR_IDX_W+1:2];
    end

    // Position and control-word registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q  <= '{x: PARK_COORD, y: PARK_COORD};
            misc_q <= '0;
        end else if (wr_en) begin
            if (addr == OFS_POS)  pos_q  <= wdata;
            if (addr == OFS_MISC) misc_q <= wdata;
        end
    end

    // Shape plane storage, one generated row pair per cursor line.
    for (genvar r = 0; r < CUR_DIM; r++) begin : g_row
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                opaq_q[r] <= '0;
                sel_q[r]  <= '0;
            end else begin
                if (opaq_wr && wr_row == CUR_IDX_W'(r)) opaq_q[r] <= wdata;
                if (sel_wr  && wr_row == CUR_IDX_W'(r)) sel_q[r]  <= wdata;
            end
        end
    end

    // Registered read port: control word with the forced bit, else zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (addr == OFS_MISC) begin
                rdata <= misc_q | (REG_DW'(1) << MISC_FORCE);
            end else begin
                rdata <= '0;
            end
        end
    end

    // Row lookup for the pixel path.
    always_comb begin
        opaq_row = opaq_q[row_idx];
        sel_row  = sel_q[row_idx];
        pos      = pos_q;
    end

    // R1
    park_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pos_q.x == PARK_COORD && pos_q.y == PARK_COORD));
    // R9
    misc_force_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_en) && $past(addr) == OFS_MISC) |-> rdata[MISC_FORCE]);
    // R9
    other_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_en) && $past(addr) != OFS_MISC) |-> rdata == '0);
endmodule

// File: rtl/cur_window.sv
// Module: cur_window
// Decides whether a pixel coordinate lies in the cursor box, and where.
// Assumes: coordinates are unsigned. The arithmetic is one bit wider so that
// position + 32 never wraps.
module cur_window
    import curs_ovl_pkg::*;
#(
    parameter int unsigned ACTIVE_W = 1024
) (
    input  logic [COORD_W-1:0]    pix_x,
    input  logic [COORD_W-1:0]    pix_y,
    input  cur_pos_t              pos,
    output logic                  covered,
    output logic [CUR_IDX_W-1:0]  row_idx,
    output logic [CUR_IDX_W-1:0]  col_idx
);
    localparam logic [COORD_W:0] WIDTH_LIM = (COORD_W+1)'(ACTIVE_W);
    localparam logic [COORD_W:0] SPAN      = (COORD_W+1)'(CUR_DIM);

    logic [COORD_W:0] dx, dy;
    logic             in_rows, in_cols, pos_ok, pix_ok;

    // Box test and row/column offsets of the pixel inside the cursor.
    always_comb begin
        dx      = {1'b0, pix_x} - {1'b0, pos.x};
        dy      = {1'b0, pix_y} - {1'b0, pos.y};
        in_rows = (pix_y >= pos.y) && (dy < SPAN);
        in_cols = (pix_x >= pos.x) && (dx < SPAN);
        pos_ok  = ({1'b0, pos.x} < WIDTH_LIM);
        pix_ok  = ({1'b0, pix_x} < WIDTH_LIM);
        covered = in_rows && in_cols && pos_ok && pix_ok;
        row_idx = dy[CUR_IDX_W-1:0];
        col_idx = dx[CUR_IDX_W-1:0];
    end
endmodule

// File: rtl/cur_mux.sv
// Module: cur_mux
// Picks the output colour of one pixel from the two shape bits.
// Assumes: the leftmost cursor column is the most significant row bit.
module cur_mux
    import curs_ovl_pkg::*;
#(
    parameter int unsigned PIX_W = 32
) (
    input  logic                  covered,
    input  logic [CUR_IDX_W-1:0]  col_idx,
    input  logic [CUR_DIM-1:0]    opaq_row,
    input  logic [CUR_DIM-1:0]    sel_row,
    input  logic [PIX_W-1:0]      pix_in,
    input  logic [PIX_W-1:0]      colour0,
    input  logic [PIX_W-1:0]      colour1,
    output logic                  draw,
    output logic [PIX_W-1:0]      pix_out
);
    logic [CUR_IDX_W-1:0] bitpos;

    // Mirror the column into a bit position and select the colour.
    always_comb begin
        bitpos  = CUR_IDX_W'(CUR_DIM - 1) - col_idx;
        draw    = covered && opaq_row[bitpos];
        if (!draw) begin
            pix_out = pix_in;
        end else if (sel_row[bitpos]) begin
            pix_out = colour1;
        end else begin
            pix_out = colour0;
        end
    end
endmodule

// File: rtl/cursor_overlay.sv
// Module: cursor_overlay (top)
// Overlays a 32x32 two-colour cursor on a palette-resolved pixel stream,
// with one cycle of latency.
// Assumes: one pixel per cycle at most, and overlay colours already resolved.
module cursor_overlay
    import curs_ovl_pkg::*;
#(
    parameter int unsigned PIX_W    = 32,
    parameter int unsigned ACTIVE_W = 1024
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic               reg_rd_en,
    input  logic [11:0]        reg_addr,
    input  logic [31:0]        reg_wdata,
    output logic [31:0]        reg_rdata,
    input  logic [PIX_W-1:0]   ovl_colour0,
    input  logic [PIX_W-1:0]   ovl_colour1,
    input  logic               in_valid,
    input  logic [15:0]        in_x,
    input  logic [15:0]        in_y,
    input  logic [PIX_W-1:0]   in_pixel,
    output logic               out_valid,
    output logic [15:0]        out_x,
    output logic [15:0]        out_y,
    output logic [PIX_W-1:0]   out_pixel
);
    cur_pos_t              pos;
    logic [CUR_IDX_W-1:0]  row_idx, col_idx;
    logic [CUR_DIM-1:0]    opaq_row, sel_row;
    logic                  covered, draw;
    logic [PIX_W-1:0]      mixed;

    cur_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr_en),
        .rd_en    (reg_rd_en),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .row_idx  (row_idx),
        .opaq_row (opaq_row),
        .sel_row  (sel_row),
        .pos      (pos)
    );

    cur_window #(.ACTIVE_W(ACTIVE_W)) u_window (
        .pix_x   (in_x),
        .pix_y   (in_y),
        .pos     (pos),
        .covered (covered),
        .row_idx (row_idx),
        .col_idx (col_idx)
    );

    cur_mux #(.PIX_W(PIX_W)) u_mux (
        .covered  (covered),
        .col_idx  (col_idx),
        .opaq_row (opaq_row),
        .sel_row  (sel_row),
        .pix_in   (in_pixel),
        .colour0  (ovl_colour0),
        .colour1  (ovl_colour1),
        .draw     (draw),
        .pix_out  (mixed)
    );

    // Output stage: one register between the input and the output pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_x     <= '0;
            out_y     <= '0;
            out_pixel <= '0;
        end else begin
            out_valid <= in_valid;
            out_x     <= in_x;
            out_y     <= in_y;
            out_pixel <= mixed;
        end
    end

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (out_valid == $past(in_valid) && out_x == $past(in_x)
                          && out_y == $past(in_y)));
    // R7
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && !$past(draw)) |-> out_pixel == $past(in_pixel));
    // R7
    overlay_colour_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(draw))
        |-> (out_pixel == $past(ovl_colour0) || out_pixel == $past(ovl_colour1)));
    // R8
    right_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, in_x} >= 17'(ACTIVE_W)) |-> !covered);
endmodule

// File: tb/cursor_overlay_tb_top.sv
module cursor_overlay_tb_top;
    localparam int unsigned PW = 32;
    localparam int unsigned AW = 1024;
    localparam logic [31:0] C0 = 32'h00A0B0C0;
    localparam logic [31:0] C1 = 32'h00102030;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr_en = 1'b0, reg_rd_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic in_valid = 1'b0;
    logic [15:0] in_x = '0, in_y = '0, out_x, out_y;
    logic [PW-1:0] in_pixel = '0, out_pixel;
    logic out_valid;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_opaq [32];
    logic [31:0] m_sel [32];
    int m_x, m_y;

    always #5 clk = ~clk;

    cursor_overlay #(.PIX_W(PW), .ACTIVE_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ovl_colour0(C0), .ovl_colour1(C1),
        .in_valid(in_valid), .in_x(in_x), .in_y(in_y), .in_pixel(in_pixel),
        .out_valid(out_valid), .out_x(out_x), .out_y(out_y), .out_pixel(out_pixel)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Bench model of the overlay result.
    function automatic logic [31:0] model(int px, int py, logic [31:0] pin);
        int r, c;
        if (py >= m_y && py < m_y + 32 && px >= m_x && px < m_x + 32
            && m_x < AW && px < AW) begin
            r = py - m_y;
            c = px - m_x;
            if (m_opaq[r][31-c]) return m_sel[r][31-c] ? C1 : C0;
        end
        return pin;
    endfunction

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic set_pos(int x, int y);
        wr(12'h8FC, {16'(x), 16'(y)});
        m_x = x; m_y = y;
    endtask

    task automatic set_row(int r, logic [31:0] o, logic [31:0] s);
        wr(12'(12'h900 + 4*r), o);
        wr(12'(12'h980 + 4*r), s);
        m_opaq[r] = o; m_sel[r] = s;
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string req);
        @(negedge clk);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk);
        reg_rd_en = 1'b0;
        chk(req, reg_rdata, exp);
    endtask

    // Present one pixel, then check it one clock later.
    task automatic pix(int px, int py, logic [31:0] pin, string req);
        logic [31:0] exp;
        exp = model(px, py, pin);
        @(negedge clk);
        in_valid = 1'b1; in_x = 16'(px); in_y = 16'(py); in_pixel = pin;
        @(negedge clk);
        in_valid = 1'b0;
        chk(req, out_pixel, exp);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 32; i++) begin m_opaq[i] = '0; m_sel[i] = '0; end
        m_x = 16'hF000; m_y = 16'hF000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 out_valid", {31'd0, out_valid}, 32'd0);

        // R1: shape filled, but the parked cursor must not show.
        for (int r = 0; r < 32; r++) set_row(r, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        pix(0, 0, 32'h11111111, "R1 parked origin");
        pix(31, 31, 32'h22222222, "R1 parked corner");
        pix(16'hF000, 16'hF000, 32'h33333333, "R1 parked at position");

        // R9: control-word read with forced bit, other reads zero.
        rd(12'h818, 32'h0200_0000, "R9 misc reset");
        wr(12'h818, 32'h0000_0055);
        rd(12'h818, 32'h0200_0055, "R9 misc stored");
        rd(12'h8FC, 32'h0, "R9 position reads zero");
        rd(12'h900, 32'h0, "R9 plane reads zero");

        // R3 R4 R6 R7: box at (100,50) with edge bits only.
        for (int r = 0; r < 32; r++) set_row(r, 32'h0, 32'h0);
        set_pos(100, 50);
        set_row(0, 32'h8000_0001, 32'h8000_0000);
        set_row(31, 32'hFFFF_FFFF, 32'h0000_0000);
        pix(100, 50, 32'h44444444, "R6 column0 bit31 select1");
        pix(131, 50, 32'h44444444, "R6 column31 bit0 select0");
        pix(101, 50, 32'h55555555, "R7 transparent passes");
        pix(99, 50, 32'h66666666, "R6 left of box");
        pix(132, 50, 32'h66666666, "R6 right of box");
        pix(100, 49, 32'h77777777, "R5 above box");
        pix(100, 81, 32'h77777777, "R5 last row");
        pix(100, 82, 32'h77777777, "R5 below box");
        chk("R3 model pos", 32'(m_x), 32'd100);

        // R8: right clip and off-screen column.
        set_row(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        set_pos(1010, 0);
        pix(1023, 0, 32'h88888888, "R8 last active column");
        pix(1024, 0, 32'h88888888, "R8 clipped column");
        set_pos(1024, 0);
        pix(1024, 0, 32'h99999999, "R8 cursor off width");
        set_pos(1010, 0);

        // R10: misaligned and unmapped writes do not alter the cursor.
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 12'h902; reg_wdata = 32'h0;
        @(negedge clk);
        reg_addr = 12'h8F8;
        @(negedge clk);
        reg_addr = 12'h8FE;
        @(negedge clk);
        reg_wr_en = 1'b0;
        pix(1010, 0, 32'hAAAAAAAA, "R10 ignored writes");

        // R10: a position write is used by the very next pixel.
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = 12'h8FC; reg_wdata = {16'd0, 16'd0};
        in_valid = 1'b1; in_x = 16'd0; in_y = 16'd0; in_pixel = 32'hBBBBBBBB;
        @(negedge clk);
        reg_wr_en = 1'b0;
        chk("R10 pixel with write edge", out_pixel, 32'hBBBBBBBB);
        m_x = 0; m_y = 0;
        in_x = 16'd5; in_pixel = 32'hCCCCCCCC;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R10 next pixel sees new pos", out_pixel, C1);

        // R2: latency of valid and coordinates.
        @(negedge clk);
        in_valid = 1'b1; in_x = 16'd321; in_y = 16'd654;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R2 valid", {31'd0, out_valid}, 32'd1);
        chk("R2 x", 32'(out_x), 32'd321);
        chk("R2 y", 32'(out_y), 32'd654);
        @(negedge clk);
        chk("R2 valid drop", {31'd0, out_valid}, 32'd0);

        // R7: random positions and shapes against the model.
        for (int k = 0; k < 20; k++) begin
            set_pos(int'($urandom_range(1100)), int'($urandom_range(900)));
            for (int r = 0; r < 32; r++) set_row(r, $urandom, $urandom);
            for (int p = 0; p < 60; p++) begin
                pix(m_x + int'($urandom_range(39)) - 4,
                    m_y + int'($urandom_range(39)) - 4, $urandom, "R7 random");
            end
        end
        finish_run();
    end
endmodule